// File: doc/BRIEF.md
# Serial DAC Front End

This block is the synchronous digital front end of a 16-bit voltage-output converter. A host writes 24-bit words over a three-wire port made of an active-low frame select, a serial clock and a data line. The block brings all three lines into the system clock domain, shifts data in on each falling serial clock edge while the frame is open, and on the last edge of a complete word loads the 16-bit code and the 2-bit output-termination select together.

A frame closed early is discarded. A word that starts with six ones is a software-reset command. Once those six ones have arrived, the command takes effect whether the frame completes or is closed early. After reset, the code output holds a build-time default, zero-scale or midscale, until a valid frame arrives. A one-cycle strobe marks every cycle in which either output takes a new value.

The system clock must run at least four times faster than the serial clock.

Top module: `serial_dac_frontend`

## Requirements
- R1: While reset is held and after it is released, the code output equals the default, the termination select is 00 and the strobe is low. The default is 0x8000 when RESET_MIDSCALE is 1 and 0x0000 otherwise.
- R2: A frame is 24 bits sent MSB first. Word bit 23 is the first bit shifted in. Bits 17:16 are the mode and bits 15:0 are the code. After the 24th falling serial clock edge, both outputs take the new values in the same cycle.
- R3: The termination select carries the mode bits unchanged: 00 drive, 01 open, 10 100k to ground, 11 1k to ground. The code output keeps the code written in the same frame whatever the mode.
- R4: If frame select rises after between 1 and 23 falling edges of a frame that is not a reset command, both outputs stay unchanged and no strobe is given. The next frame is decoded from a cleared shift register.
- R5: Once 24 edges have been received, further serial clock edges while frame select stays low are ignored. A new frame needs frame select to rise and fall again.
- R6: If frame select is low when reset is released and has not yet risen, serial clock edges change nothing.
- R7: A complete frame of 24 ones returns both outputs to their reset values.
- R8: A frame whose first six bits are all ones is a reset command once the sixth bit has arrived. An early rise of frame select after that point still returns both outputs to their reset values. An early rise before the sixth bit changes nothing.
- R9: The strobe is high for exactly one cycle whenever the code or the termination select changes. It is low in every other cycle, including after a frame that rewrites the current values.
- R10: If frame select rises in the same system cycle as the 24th falling edge arrives, the frame is accepted.
- R11: Bits 23:18 that are not all ones are ignored. Such a frame acts as an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, data taken on falling edges |
| sdin_i | input | 1 | Serial data, MSB first |
| dac_code_o | output | 16 | Held converter code |
| term_sel_o | output | 2 | Output termination select (mode) |
| update_o | output | 1 | One-cycle strobe on any output change |

## Verification
Two events can land in the same synchronized cycle: the 24th falling serial edge, which commits the word, and a rise of frame select, which would otherwise cancel it. The bench provokes this by dropping the serial clock and raising frame select on the same system clock edge. Both lines pass through synchronizers of equal depth, so they arrive together. The bench judges the result by requiring the new code, the new mode and exactly one strobe. The early-close sweep covers the other side of that boundary: it closes the frame after every edge count from 1 to 23, for both a plain word and an all-ones word.

// File: rtl/sdac_pkg.sv
// Package: shared types for the serial DAC front end.
// Assumes: the mode field is two bits wide by protocol.
package sdac_pkg;

    localparam int MODE_W = 2;

    // Output termination selected by the mode bits
    typedef enum logic [MODE_W-1:0] {
        TERM_DRIVE = 2'b00,
        TERM_OPEN  = 2'b01,
        TERM_100K  = 2'b10,
        TERM_1K    = 2'b11
    } term_e;

    // Frame receiver state
    typedef enum logic {
        FR_WAIT  = 1'b0,
        FR_SHIFT = 1'b1
    } frame_st_e;

endpackage

// File: rtl/sdac_sync.sv
// Module: multi-bit synchronizer chain for independent asynchronous levels.
// Assumes: each bit is a slow level, so per-bit skew of one cycle is harmless.
module sdac_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sdac_frame.sv
// Module: frame receiver. Detects edges on the synchronized lines, shifts
// data on serial clock falls and issues a one-cycle load or reset command.
// Assumes: inputs are already synchronized with equal latency.
module sdac_frame
    import sdac_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int PAD_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n_s,
    input  logic              sclk_s,
    input  logic              sdin_s,
    output logic              load_p,
    output logic              rst_p,
    output logic [CODE_W-1:0] load_code,
    output logic [MODE_W-1:0] load_mode
);

    localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] ARM_IDX  = CNT_W'(PAD_W - 1);

    frame_st_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [FRAME_W-2:0]   shreg;
    logic [FRAME_W-1:0]   nxt;
    logic                 armed;
    logic                 sclk_d;
    logic                 frame_d;
    logic                 sclk_fall;
    logic                 frame_fall;
    logic                 arm_now;

    // Edge detection and the candidate word after this bit
    always_comb begin
        sclk_fall  = sclk_d & ~sclk_s;
        frame_fall = frame_d & ~frame_n_s;
        nxt        = {shreg, sdin_s};
        arm_now    = (cnt == ARM_IDX) && (&nxt[PAD_W-1:0]);
    end

    // Delayed copies for edge detection; frame select starts low so a rise is required
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b1;
            frame_d <= 1'b0;
        end else begin
            sclk_d  <= sclk_s;
            frame_d <= frame_n_s;
        end
    end

    // Frame state machine: start, shift, commit, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FR_WAIT;
            cnt       <= '0;
            shreg     <= '0;
            armed     <= 1'b0;
            load_p    <= 1'b0;
            rst_p     <= 1'b0;
            load_code <= '0;
            load_mode <= '0;
        end else begin
            load_p <= 1'b0;
            rst_p  <= 1'b0;
            case (state)
                FR_WAIT: begin
                    if (frame_fall) begin
                        state <= FR_SHIFT;
                        cnt   <= '0;
                        shreg <= '0;
                        armed <= 1'b0;
                    end
                end
                FR_SHIFT: begin
                    if (sclk_fall && cnt == LAST_IDX) begin
                        state <= FR_WAIT;
                        cnt   <= '0;
                        shreg <= '0;
                        armed <= 1'b0;
                        if (armed || (&nxt)) begin
                            rst_p <= 1'b1;
                        end else begin
                            load_p    <= 1'b1;
                            load_code <= nxt[CODE_W-1:0];
                            load_mode <= nxt[CODE_W +: MODE_W];
                        end
                    end else if (frame_n_s) begin
                        state <= FR_WAIT;
                        cnt   <= '0;
                        shreg <= '0;
                        armed <= 1'b0;
                        if (armed) rst_p <= 1'b1;
                    end else if (sclk_fall) begin
                        shreg <= nxt[FRAME_W-2:0];
                        cnt   <= cnt + 1'b1;
                        if (arm_now) armed <= 1'b1;
                    end
                end
                default: state <= FR_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/sdac_hold.sv
// Module: code and mode holding registers with power-on default and change strobe.
// Assumes: load and reset commands are never issued in the same cycle.
module sdac_hold
    import sdac_pkg::*;
#(
    parameter int   CODE_W         = 16,
    parameter logic RESET_MIDSCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_p,
    input  logic              rst_p,
    input  logic [CODE_W-1:0] load_code,
    input  logic [MODE_W-1:0] load_mode,
    output logic [CODE_W-1:0] code_o,
    output term_e             mode_o,
    output logic              upd_o
);

    logic [CODE_W-1:0] def_code;
    logic [CODE_W-1:0] code_n;
    term_e             mode_n;

    // Pick the default code variant
    generate
        if (RESET_MIDSCALE) begin : g_mid
            assign def_code = {1'b1, {(CODE_W-1){1'b0}}};
        end else begin : g_zero
            assign def_code = '0;
        end
    endgenerate

    // Next register values from the pending command
    always_comb begin
        code_n = code_o;
        mode_n = mode_o;
        if (rst_p) begin
            code_n = def_code;
            mode_n = TERM_DRIVE;
        end else if (load_p) begin
            code_n = load_code;
            mode_n = term_e'(load_mode);
        end
    end

    // Hold registers and raise the strobe when a value actually changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= def_code;
            mode_o <= TERM_DRIVE;
            upd_o  <= 1'b0;
        end else begin
            code_o <= code_n;
            mode_o <= mode_n;
            upd_o  <= (code_n != code_o) || (mode_n != mode_o);
        end
    end

endmodule

// File: rtl/serial_dac_frontend.sv
// Module: top of the serial DAC front end. Synchronizes the three port
// lines, receives frames and holds the code and termination select.
// Assumes: clk runs at least four times the serial clock rate.
module serial_dac_frontend
    import sdac_pkg::*;
#(
    parameter int   CODE_W         = 16,
    parameter int   PAD_W          = 6,
    parameter int   SYNC_STAGES    = 2,
    parameter logic RESET_MIDSCALE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [1:0]        term_sel_o,
    output logic              update_o
);

    logic [2:0]        sync_q;
    logic              load_p;
    logic              rst_p;
    logic [CODE_W-1:0] load_code;
    logic [MODE_W-1:0] load_mode;
    term_e             mode_q;

    sdac_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({frame_n_i, sclk_i, sdin_i}),
        .q_o   (sync_q)
    );

    sdac_frame #(
        .CODE_W (CODE_W),
        .PAD_W  (PAD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n_s (sync_q[2]),
        .sclk_s    (sync_q[1]),
        .sdin_s    (sync_q[0]),
        .load_p    (load_p),
        .rst_p     (rst_p),
        .load_code (load_code),
        .load_mode (load_mode)
    );

    sdac_hold #(
        .CODE_W         (CODE_W),
        .RESET_MIDSCALE (RESET_MIDSCALE)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_p    (load_p),
        .rst_p     (rst_p),
        .load_code (load_code),
        .load_mode (load_mode),
        .code_o    (dac_code_o),
        .mode_o    (mode_q),
        .upd_o     (update_o)
    );

    assign term_sel_o = mode_q;

endmodule

// File: rtl/sdac_checker.sv
// Module: property checker for serial_dac_frontend, attached by bind.
// Assumes: sees the receiver commands and the top outputs.
module sdac_checker #(
    parameter int   CODE_W         = 16,
    parameter logic RESET_MIDSCALE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_p,
    input logic              rst_p,
    input logic [CODE_W-1:0] load_code,
    input logic [1:0]        load_mode,
    input logic [CODE_W-1:0] dac_code_o,
    input logic [1:0]        term_sel_o,
    input logic              update_o
);

    localparam logic [CODE_W-1:0] DEF_CODE =
        RESET_MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

    assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_p && rst_p));

    assert_load_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_p) |-> (dac_code_o == $past(load_code)) && (term_sel_o == $past(load_mode)));

    assert_soft_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_p) |-> (dac_code_o == DEF_CODE) && (term_sel_o == 2'b00));

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_p) && !$past(rst_p)) |-> ($stable(dac_code_o) && $stable(term_sel_o)));

    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_code_o) || !$stable(term_sel_o)) |-> update_o);

    assert_strobe_only_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (!$stable(dac_code_o) || !$stable(term_sel_o)));

endmodule

bind serial_dac_frontend sdac_checker #(
    .CODE_W         (CODE_W),
    .RESET_MIDSCALE (RESET_MIDSCALE)
) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_p     (load_p),
    .rst_p      (rst_p),
    .load_code  (load_code),
    .load_mode  (load_mode),
    .dac_code_o (dac_code_o),
    .term_sel_o (term_sel_o),
    .update_o   (update_o)
);

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;

    localparam logic [15:0] DEF = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic [15:0] code;
    logic [1:0]  term;
    logic        upd;

    int tests = 0;
    int fails = 0;
    int upd_cnt = 0;
    int base = 0;
    bit done = 1'b0;

    logic [15:0] m_code = DEF;
    logic [1:0]  m_mode = 2'b00;
    int          m_delta = 0;

    always #2 clk = ~clk;

    serial_dac_frontend #(.RESET_MIDSCALE(1'b1)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n_i  (frame_n),
        .sclk_i     (sclk),
        .sdin_i     (sdin),
        .dac_code_o (code),
        .term_sel_o (term),
        .update_o   (upd)
    );

    // Count strobe cycles away from the active edge
    always @(negedge clk) if (rst_n && upd) upd_cnt++;

    task automatic check(input string tag);
        tests++;
        if (code !== m_code || term !== m_mode || (upd_cnt - base) != m_delta) begin
            fails++;
            $display("FAIL %s: code=%h term=%b strobes=%0d expected code=%h term=%b strobes=%0d",
                     tag, code, term, upd_cnt - base, m_code, m_mode, m_delta);
        end
    endtask

    task automatic model_set(input logic [15:0] c, input logic [1:0] m);
        m_delta = (c != m_code || m != m_mode) ? 1 : 0;
        m_code  = c;
        m_mode  = m;
    endtask

    task automatic model_write(input logic [23:0] w);
        if (&w[23:18]) model_set(DEF, 2'b00);
        else           model_set(w[15:0], w[17:16]);
    endtask

    task automatic bit_out(input logic b);
        sdin = b;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
    endtask

    task automatic open_frame();
        base    = upd_cnt;
        m_delta = 0;
        frame_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (2) @(negedge clk);
        frame_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w, input int nbits);
        open_frame();
        for (int i = 0; i < nbits; i++) bit_out(w[23-i]);
        close_frame();
    endtask

    task automatic full_write(input logic [23:0] w);
        send(w, 24);
        model_write(w);
    endtask

    initial begin
        // R1 / R6: reset with frame select already low
        repeat (5) @(negedge clk);
        tests++;
        if (code !== DEF || term !== 2'b00 || upd !== 1'b0) begin
            fails++;
            $display("FAIL R1: code=%h term=%b upd=%b expected code=%h term=00 upd=0", code, term, upd, DEF);
        end
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        base = upd_cnt; m_delta = 0;
        check("R1 after release");
        for (int i = 0; i < 24; i++) bit_out(((24'h011234 >> (23 - i)) & 24'h1) != 0);
        repeat (8) @(negedge clk);
        check("R6 no frame without a frame-select fall");
        frame_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 / R3: every mode with a walking-one code pattern
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] c;
                c = (16'h1 << b) ^ (16'(m) * 16'h1111);
                full_write({6'b0, 2'(m), c});
                check($sformatf("R2 R3 mode=%0d bit=%0d", m, b));
            end
        end

        // R9: rewriting the held values gives no strobe
        full_write({6'b0, 2'b11, 16'h3333 ^ 16'h8000});
        check("R9 first write");
        full_write({6'b0, 2'b11, 16'h3333 ^ 16'h8000});
        check("R9 repeat write has no strobe");

        // R11: pad bits not all ones are ignored
        full_write({6'b101101, 2'b10, 16'hBEEF});
        check("R11 pad ignored");

        // R4: close the frame early after every edge count
        full_write({6'b0, 2'b01, 16'h0F0F});
        for (int k = 1; k < 24; k++) begin
            send({6'b0, 2'b11, 16'h5A5A}, k);
            m_delta = 0;
            check($sformatf("R4 abort after %0d edges", k));
        end
        full_write({6'b0, 2'b10, 16'hC3A5});
        check("R4 clean frame after aborts");

        // R5: extra edges after the 24th are ignored
        open_frame();
        for (int i = 0; i < 24; i++) bit_out(((24'h0024D1 >> (23 - i)) & 24'h1) != 0);
        for (int i = 0; i < 8; i++) bit_out(1'b1);
        close_frame();
        model_write(24'h0024D1);
        check("R5 trailing edges ignored");

        // R7: all-ones frame restores defaults
        full_write(24'hFFFFFF);
        check("R7 software reset");

        // R8: all-ones frame closed early after k edges
        for (int k = 1; k < 24; k++) begin
            full_write({6'b0, 2'b01, 16'h0F0F});
            send(24'hFFFFFF, k);
            if (k >= 6) model_set(DEF, 2'b00);
            else        m_delta = 0;
            check($sformatf("R8 reset frame closed after %0d edges", k));
        end

        // R10: frame select rises in the same cycle as the 24th fall
        open_frame();
        for (int i = 0; i < 23; i++) bit_out(((24'h017E81 >> (23 - i)) & 24'h1) != 0);
        sdin = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        frame_n = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        model_write(24'h017E81);
        check("R10 coincident close accepted");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule